// File: doc/BRIEF.md
# Serial Peripheral Master with Frame Queues

This block is a memory-mapped SPI master. Software writes transmit frames into an eight-entry queue through a small register window. A serial engine takes frames from that queue one after another and shifts each one out most significant bit first, while it collects the same number of bits from the input line. Each received frame goes into a second eight-entry queue, and software reads it back through the data address. The frame length runs from 4 to 16 bits. All four combinations of clock idle level and sampling edge are supported, and the bit rate comes from a prescaler and a divisor.

Queue-level requests and a receive-overrun flag are gated by enable bits and merged onto one interrupt line. A loopback mode routes the outgoing bit stream straight back to the receiver without driving the data pin. The register window is halfword wide and is indexed by address bits 4:2.

Top module: `spi_fifo_master`

## Requirements
- R1: Registers by word index: 0 config (bits 3:0 length code, bit 6 phase, bit 7 polarity, bits 15:8 divisor), 1 control (bit 0 rx-request enable, bit 1 tx-request enable, bit 2 overrun enable, bit 3 loopback, bit 4 run, bits 6:5 stored only), 2 data, 3 status, 4 prescale (8 bits), 5 interrupt. Config, control and prescale read back as written. Writes to status have no effect. Unused indices read zero.
- R2: Each queue holds 8 frames. A data write to a full transmit queue is dropped. Status bits: 0 tx empty, 1 tx not full, 2 rx not empty, 3 rx full, 4 busy.
- R3: A read of the data address returns the oldest received frame right-justified with upper bits zero and removes it. A read of the data address with nothing received returns zero and leaves the queue unchanged.
- R4: Frame length is the length code plus one. Codes 0 to 2 give 4-bit frames. Bits go out most significant first, and received frames never carry bits above the frame length.
- R5: The half bit time is max(1, prescale>>1) x (divisor+1) clock cycles. While running and idle, a frame is taken one cycle after the transmit queue is seen non-empty. Its first clock edge comes one half bit time later, and it lasts 2N half bit times.
- R6: The serial clock rests at the polarity bit. With phase 0, the input is sampled on the 1st, 3rd, ... edges and the output changes on the others. With phase 1, this is reversed.
- R7: Every completed frame produces exactly one received frame, which enters the receive queue at its last edge.
- R8: While the run bit is low, the engine is idle. Clearing the run bit mid-frame abandons that frame without receiving it, and the clock returns to its rest level.
- R9: In loopback the receiver takes the outgoing bit and the data output stays low. Outside a frame the data output is always low.
- R10: Busy is high while a frame is in flight, or while the run bit is set and the transmit queue is non-empty.
- R11: The receive request is high with 4 or more frames received. The transmit request is high with 4 or fewer frames queued. The interrupt register reads {overrun, tx request, rx request} at bits 2:0, each ANDed with its enable, and the interrupt output is their OR.
- R12: A frame that completes while the receive queue is full is dropped and sets the overrun flag. Any write to index 5 clears the flag, but a new overrun in the same cycle wins.
- R13: Control bits 5 and 6 are kept and read back but change no behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_sel | input | 1 | access strobe for this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | register word index (byte address bits 4:2) |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data, valid in the strobe cycle |
| sclk | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| irq | output | 1 | combined interrupt |

## Verification
The reference model is driven with a pseudo-random input bit stream in all four clock modes. This separates sampling-edge errors from output-edge errors. The stream is run at 8-, 16- and clamped 4-bit lengths, which exposes length decoding and bit ordering. Loopback runs check that the written value returns masked to the frame length, independently of the model. Overfilled queues separate dropped writes and overrun discards from normal flow. A frame abandoned by clearing the run bit shows that nothing is received. Interrupt reads at chosen queue levels pin down the request thresholds.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:2]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALFQ = CW'(DEPTH / 2);

  logic [15:0] cfg;
  logic [6:0]  ctl;
  logic [7:0]  pre_r;
  logic        ovr;

  logic [15:0] txm [DEPTH];
  logic [15:0] rxm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic        act, dout;
  logic [15:0] cnt, txsr, rxsr;
  logic [4:0]  e;

  wire wr_en = bus_sel & bus_wr;
  wire rd_en = bus_sel & ~bus_wr;
  wire en    = ctl[4];
  wire cpha  = cfg[6];
  wire cpol  = cfg[7];
  wire lb    = ctl[3];

  wire [3:0]  msb  = (cfg[3:0] < 4'd3) ? 4'd3 : cfg[3:0];
  wire [6:0]  pre  = (pre_r[7:1] == 7'd0) ? 7'd1 : pre_r[7:1];
  wire [8:0]  dv   = {1'b0, cfg[15:8]} + 9'd1;
  wire [15:0] half = {9'd0, pre} * {7'd0, dv};

  wire        tick     = act && (cnt == half - 16'd1);
  wire        sample_e = (e[0] == cpha);
  wire        last     = (e == {msb, 1'b1});
  wire        din      = lb ? dout : miso;
  wire [15:0] rx_next  = sample_e ? {rxsr[14:0], din} : rxsr;
  wire        done     = tick && last;
  wire [15:0] w        = txm[tx_rp];

  wire tx_pop  = en && !act && (tx_cnt != '0);
  wire tx_push = wr_en && (bus_addr == 3'd2) && (tx_cnt != FULL);
  wire rx_pop  = rd_en && (bus_addr == 3'd2) && (rx_cnt != '0);
  wire rx_push = done && (rx_cnt != FULL);
  wire rx_ovf  = done && (rx_cnt == FULL);

  wire       busy = act || (en && tx_cnt != '0);
  wire [4:0] stat = {busy, rx_cnt == FULL, rx_cnt != '0, tx_cnt != FULL, tx_cnt == '0};
  wire [2:0] mis  = {ovr & ctl[2], (tx_cnt <= HALFQ) & ctl[1], (rx_cnt >= HALFQ) & ctl[0]};

  assign irq  = |mis;
  assign mosi = act & ~lb & dout;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = cfg;
      3'd1:    bus_rdata = {9'd0, ctl};
      3'd2:    bus_rdata = (rx_cnt != '0) ? rxm[rx_rp] : 16'd0;
      3'd3:    bus_rdata = {11'd0, stat};
      3'd4:    bus_rdata = {8'd0, pre_r};
      3'd5:    bus_rdata = {13'd0, mis};
      default: bus_rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; ctl <= '0; pre_r <= '0; ovr <= 1'b0;
    end else begin
      if (wr_en && bus_addr == 3'd0) cfg <= bus_wdata;
      if (wr_en && bus_addr == 3'd1) ctl <= bus_wdata[6:0];
      if (wr_en && bus_addr == 3'd4) pre_r <= bus_wdata[7:0];
      if (rx_ovf) ovr <= 1'b1;
      else if (wr_en && bus_addr == 3'd5) ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= bus_wdata;
    if (rx_push) rxm[rx_wp] <= rx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      tx_cnt <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; sclk <= 1'b0; cnt <= '0; e <= '0;
      txsr <= '0; rxsr <= '0; dout <= 1'b0;
    end else if (!en) begin
      act  <= 1'b0;
      sclk <= cpol;
    end else if (!act) begin
      sclk <= cpol;
      if (tx_cnt != '0) begin
        act  <= 1'b1;
        cnt  <= '0;
        e    <= '0;
        rxsr <= '0;
        dout <= w[msb];
        txsr <= cpha ? w : (w << 1);
      end
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
      e    <= e + 5'd1;
      rxsr <= rx_next;
      if (!sample_e) begin
        dout <= txsr[msb];
        txsr <= txsr << 1;
      end
      if (last) act <= 1'b0;
    end else begin
      cnt <= cnt + 16'd1;
    end
  end

  assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);
  assert_ovr_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_cnt) == FULL);
  assert_rx_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> ((rx_next >> msb) >> 1) == 16'd0);
  assert_clock_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && $stable(cpol)) |-> sclk == cpol);
  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !act);
endmodule

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:2] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic sclk, mosi, irq, miso;
  logic [15:0] lfsr = 16'hACE1;
  int checks = 0, fails = 0;
  bit go = 0, ended = 0;

  always #2 clk = ~clk;
  assign miso = lfsr[0];
  always @(negedge clk) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  spi_fifo_master #(.DEPTH(DEPTH)) u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .irq(irq));

  // reference model state
  logic [15:0] cr0; logic [6:0] cr1; logic [7:0] cps;
  bit ovr, m_act, m_sclk, dout, done, full, din;
  int cnt, e, ob, w, r, a, n, h, pv, txs, rxs;
  int qtx[$], qrx[$];

  function automatic int m_read(input int idx);
    int busy, st, mi;
    busy = (m_act || (cr1[4] && qtx.size() > 0)) ? 1 : 0;
    st = (busy << 4) | ((qrx.size() == DEPTH) << 3) | ((qrx.size() > 0) << 2)
       | ((qtx.size() < DEPTH) << 1) | (qtx.size() == 0);
    mi = ((ovr && cr1[2]) << 2) | ((qtx.size() <= DEPTH / 2 && cr1[1]) << 1)
       | (qrx.size() >= DEPTH / 2 && cr1[0]);
    case (idx)
      0: return int'(cr0);
      1: return int'(cr1);
      2: return (qrx.size() > 0) ? qrx[0] : 0;
      3: return st;
      4: return int'(cps);
      5: return mi;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cr0 = 0; cr1 = 0; cps = 0; ovr = 0; m_act = 0; m_sclk = 0; dout = 0;
      cnt = 0; e = 0; ob = 0; w = 0; r = 0; qtx.delete(); qrx.delete();
    end else begin
      a = int'(bus_addr);
      n = (cr0[3:0] < 3) ? 4 : int'(cr0[3:0]) + 1;
      pv = (cps >> 1) == 0 ? 1 : int'(cps >> 1);
      h = pv * (int'(cr0[15:8]) + 1);
      txs = qtx.size(); rxs = qrx.size(); done = 0;
      if (!cr1[4]) begin
        m_act = 0; m_sclk = cr0[7];
      end else if (!m_act) begin
        m_sclk = cr0[7];
        if (txs > 0) begin
          w = qtx.pop_front(); m_act = 1; cnt = 0; e = 0; r = 0;
          dout = ((w >> (n - 1)) & 1) != 0; ob = cr0[6] ? 0 : 1;
        end
      end else if (cnt == h - 1) begin
        cnt = 0; m_sclk = !m_sclk;
        if (((e % 2) == 1) == cr0[6]) begin
          din = cr1[3] ? dout : miso;
          r = ((r << 1) | int'(din)) & 16'hFFFF;
        end else begin
          dout = (ob < n) ? (((w >> (n - 1 - ob)) & 1) != 0) : 1'b0;
          ob++;
        end
        if (e == 2 * n - 1) begin m_act = 0; done = 1; end
        e++;
      end else cnt++;
      full = (rxs == DEPTH);
      if (bus_sel && !bus_wr && a == 2 && rxs > 0) void'(qrx.pop_front());
      if (done && !full) qrx.push_back(r);
      if (bus_sel && bus_wr)
        case (a)
          0: cr0 = bus_wdata;
          1: cr1 = bus_wdata[6:0];
          2: if (txs < DEPTH) qtx.push_back(int'(bus_wdata));
          4: cps = bus_wdata[7:0];
          5: ovr = 0;
          default: ;
        endcase
      if (done && full) ovr = 1;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && go) begin
      chk("R6 sclk", int'(sclk), int'(m_sclk));
      chk("R9 mosi", int'(mosi), int'(m_act && !cr1[3] && dout));
      chk("R11 irq", int'(irq), int'(m_read(5) != 0));
    end

  task automatic wr(input int idx, input int v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'(idx); bus_wdata = 16'(v);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int idx, input string tag, output int v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 3'(idx);
    #1;
    v = int'(bus_rdata);
    chk(tag, v, m_read(idx));
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle();
    while (m_act || qtx.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int v, fld, msk;
    int words[10];
    repeat (3) @(negedge clk);
    rst_n = 1; go = 1;
    // reset state
    rd(0, "R1 cfg reset", v); chk("R1 cfg reset", v, 0);
    rd(1, "R1 ctl reset", v); chk("R1 ctl reset", v, 0);
    rd(3, "R2 status reset", v); chk("R2 status reset", v, 3);
    rd(5, "R11 int reset", v); chk("R11 int reset", v, 0);
    rd(2, "R3 empty read", v); chk("R3 empty read", v, 0);
    rd(3, "R3 status after empty read", v); chk("R3 status after empty read", v, 3);
    rd(7, "R1 unused index", v); chk("R1 unused index", v, 0);
    // readback
    wr(0, 16'h5AC7); rd(0, "R1 cfg", v); chk("R1 cfg", v, 16'h5AC7);
    wr(1, 16'hFF60); rd(1, "R13 ctl slave bits", v); chk("R13 ctl slave bits", v, 16'h60);
    wr(4, 16'h12A5); rd(4, "R1 prescale", v); chk("R1 prescale", v, 16'hA5);
    wr(3, 16'hFFFF); rd(3, "R1 status write ignored", v); chk("R1 status write ignored", v, 3);
    wr(1, 0);
    // modes and lengths against the model, then loopback independently
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 3; s++) begin
        fld = (s == 0) ? 7 : (s == 1) ? 15 : 1;
        msk = (s == 0) ? 16'hFF : (s == 1) ? 16'hFFFF : 16'hF;
        wr(0, (1 << 8) | (m << 6) | fld);
        wr(4, 2);
        wr(1, 16'h10);
        for (int k = 0; k < 3; k++) wr(2, 16'hA53C ^ (k * 16'h1357) ^ (m << 12));
        rd(3, "R10 busy in flight", v); chk("R10 busy in flight", (v >> 4) & 1, 1);
        idle();
        rd(3, "R10 busy idle", v); chk("R10 busy idle", (v >> 4) & 1, 0);
        for (int k = 0; k < 3; k++) rd(2, "R7 received frame", v);
        rd(3, "R7 queue drained", v); chk("R7 queue drained", v, 3);
        wr(1, 16'h78);
        for (int k = 0; k < 2; k++) wr(2, 16'hC3E1 + k * 16'h0F0F + m);
        idle();
        for (int k = 0; k < 2; k++) begin
          rd(2, "R9 loopback", v);
          chk("R4 R9 R13 loopback value", v, (16'hC3E1 + k * 16'h0F0F + m) & msk);
        end
        wr(1, 0);
      end
    // full transmit queue drops writes
    wr(0, 16'h0107); wr(4, 2);
    for (int k = 0; k < 10; k++) begin words[k] = 16'h11 * (k + 1); wr(2, words[k]); end
    rd(3, "R2 tx full status", v); chk("R2 tx full status", v, 0);
    wr(1, 16'h18); idle();
    rd(3, "R2 rx full status", v); chk("R2 rx full status", v, 16'h0F);
    for (int k = 0; k < 8; k++) begin rd(2, "R2 kept frames", v); chk("R2 kept frames", v, words[k] & 16'hFF); end
    // overrun
    wr(1, 16'h1C);
    for (int k = 0; k < 10; k++) wr(2, 16'h40 + k);
    idle();
    rd(5, "R12 overrun flagged", v); chk("R12 overrun flagged", v, 4);
    chk("R12 irq on overrun", int'(irq), 1);
    for (int k = 0; k < 8; k++) begin rd(2, "R12 discard", v); chk("R12 discard", v, 16'h40 + k); end
    rd(3, "R12 extra frames gone", v); chk("R12 extra frames gone", v, 3);
    wr(5, 16'h1234);
    rd(5, "R12 cleared", v); chk("R12 cleared", v, 0);
    // request thresholds
    wr(1, 16'h03);
    rd(5, "R11 tx request empty", v); chk("R11 tx request empty", v, 2);
    for (int k = 0; k < 5; k++) wr(2, 16'h70 + k);
    rd(5, "R11 tx five queued", v); chk("R11 tx five queued", v, 0);
    wr(1, 16'h1B); idle();
    rd(5, "R11 rx five held", v); chk("R11 rx five held", v, 3);
    rd(2, "R3 pop", v); rd(2, "R3 pop", v);
    rd(5, "R11 rx three held", v); chk("R11 rx three held", v, 2);
    for (int k = 0; k < 3; k++) rd(2, "R3 pop", v);
    // abort on run bit low
    wr(1, 0); wr(0, (9 << 8) | 16'h87); wr(4, 20);
    wr(1, 16'h10); wr(2, 16'hB6);
    repeat (300) @(negedge clk);
    rd(3, "R5 R10 mid slow frame", v); chk("R10 mid slow frame", v, 16'h13);
    wr(1, 0);
    rd(3, "R8 halted", v); chk("R8 halted", v, 3);
    repeat (2000) @(negedge clk);
    rd(3, "R8 nothing received", v); chk("R8 nothing received", v, 3);
    chk("R8 clock at rest", int'(sclk), 1);
    summary();
  end
endmodule